// File: doc/BRIEF.md
# SD Host Single-Segment DMA Engine

This block moves block data between the card-side data FIFO of an SD/SDIO host and system memory, one contiguous segment per transfer. Software programs a start address, a mode word and the host's block size and block count, then writes a start bit. The engine issues one 64-bit memory beat per handshake until the rounded-up byte total has been moved, and then raises a per-channel completion flag.

Two direction channels exist. Channel 0 reads memory and feeds the card (write commands). Channel 1 takes card data and writes it to memory (read commands). Each channel has its own active-low soft reset that aborts work in flight. A start is refused with an error when the start address is not on a 128-byte boundary. Status bits clear when zero is written to them. The interrupt line is the OR of every status bit whose mask bit is zero.

Top module: `sd_dma_engine`

## Requirements
- R1: After reset both mask registers (0x848, 0x858) read 0xFFFFFFFF, both status registers (0x840, 0x850) read 0, the reset register (0x830) reads 0xFFFFFFFF, the control register (0x828) reads 0 and `irq` is low.
- R2: The mode register (0x820) keeps bit 16 (channel: 0 = memory to card, 1 = card to memory), bits 5:4 (bus-width code, stored only) and bit 0 (1 = incrementing address, 0 = fixed). Every other bit reads 0. The start address register (0x880) reads back what was written.
- R3: Writing 1 to bit 0 of 0x828 starts a transfer using the current mode, address and size. Bit 0 of 0x828 reads 1 while a transfer is active. A start written while active is ignored.
- R4: A channel 1 transfer makes ceil(block_size*block_count/8) memory beats with `mem_we`=1. Each beat's write data is the current card receive word, and `card_rx_pop` pulses on each accepted beat.
- R5: A channel 0 transfer makes the same number of beats with `mem_we`=0. The data returned by each beat is presented on `card_tx_data` with `card_tx_valid` in the same cycle. Beats are issued only while `card_tx_ready` is high.
- R6: In incrementing mode beat k targets start+8k. In fixed mode every beat targets the start address.
- R7: The clock edge that accepts the last beat sets completion bit 16 (channel 0) or bit 20 (channel 1), or bit 17 for channel 1 when LEGACY_LAYOUT=1. A start with a zero byte total sets the completion bit at once and makes no beat.
- R8: Writing a status register ANDs it with the written word. A 0 bit clears and a 1 bit leaves the bit unchanged.
- R9: A start whose address has any of bits 6:0 set makes no beat, never becomes active, and sets error bit 16 (channel 0) or 17 (channel 1) in 0x850.
- R10: Bits 8 and 9 of 0x830 are active-low resets for channel 0 and channel 1. Writing 0 aborts that channel's active transfer with no completion flag. Starts on a channel held in reset are ignored. All other bits of 0x830 read as 1.
- R11: `irq` is high exactly when some status bit is set whose mask bit is 0. A mask bit of 1 suppresses that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| blk_size | input | 16 | Bytes per block from the host |
| blk_count | input | 32 | Number of blocks from the host |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid with mem_rdy |
| mem_rdy | input | 1 | Beat accepted when high with mem_req |
| card_rx_valid | input | 1 | Card receive word available |
| card_rx_data | input | 64 | Card receive word |
| card_rx_pop | output | 1 | Consume card receive word |
| card_tx_valid | output | 1 | Word for the card transmit FIFO |
| card_tx_data | output | 64 | Card transmit word |
| card_tx_ready | input | 1 | Card transmit FIFO has space |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted address counter shows up on the first memory beat after the fault, as an address that is off the +8 step or that moves in fixed mode. A wrong remaining-beat count shows up either as an extra beat after the expected stream runs out or as a completion bit that never appears. A bad busy or channel-select state shows up within one beat as the wrong `mem_we` polarity, as requests while idle, or as a second start that is not ignored. The bench compares every beat against a queued expectation and reads the status words back after each scenario, so such faults are caught within a cycle or two of the first wrong beat.

// File: rtl/sd_dma_pkg.sv
// Shared constants and types for the SD host DMA engine.
// Assumes a 12-bit register byte offset and 32-bit register words.
package sd_dma_pkg;
    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFS_MODE     = 12'h820;
    localparam logic [REG_AW-1:0] OFS_CTRL     = 12'h828;
    localparam logic [REG_AW-1:0] OFS_RST      = 12'h830;
    localparam logic [REG_AW-1:0] OFS_DONE     = 12'h840;
    localparam logic [REG_AW-1:0] OFS_DONE_MSK = 12'h848;
    localparam logic [REG_AW-1:0] OFS_ERR      = 12'h850;
    localparam logic [REG_AW-1:0] OFS_ERR_MSK  = 12'h858;
    localparam logic [REG_AW-1:0] OFS_ADDR     = 12'h880;

    localparam int MODE_CH_BIT    = 16;
    localparam int MODE_WID_LO    = 4;
    localparam int MODE_INCR_BIT  = 0;
    localparam int RST_CH0_BIT    = 8;
    localparam int RST_CH1_BIT    = 9;
    localparam int DONE_CH0_BIT   = 16;
    localparam int DONE_CH1_BIT   = 20;
    localparam int DONE_CH1_OLD   = 17;
    localparam int ERR_CH0_BIT    = 16;
    localparam int ERR_CH1_BIT    = 17;

    typedef enum logic {
        CH_TO_CARD = 1'b0,
        CH_TO_MEM  = 1'b1
    } dma_ch_e;

    typedef struct packed {
        dma_ch_e    ch;
        logic [1:0] width;
        logic       incr;
    } dma_mode_t;
endpackage

// File: rtl/sd_dma_regs.sv
// Register file and start decision for the SD host DMA engine.
// Holds mode, address, channel resets, status and masks; decides whether a
// start is refused (busy / channel in reset), errored (misaligned), finished
// at once (zero bytes) or launched. Assumes one register write per cycle.
module sd_dma_regs
    import sd_dma_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int ALIGN_LSB     = 7,
    parameter int LEGACY_LAYOUT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              xfer_busy,
    input  logic              xfer_done,
    input  dma_ch_e           xfer_done_ch,
    input  logic              xfer_empty,
    output logic              start_go,
    output dma_ch_e           start_ch,
    output logic              start_incr,
    output logic [ADDR_W-1:0] start_addr,
    output logic [1:0]        chan_rel,
    output logic              irq,
    output logic [31:0]       done_st,
    output logic [31:0]       err_st
);
    localparam int DONE1_POS = (LEGACY_LAYOUT != 0) ? DONE_CH1_OLD : DONE_CH1_BIT;

    dma_mode_t         mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       done_msk;
    logic [31:0]       err_msk;
    logic [31:0]       done_set;
    logic [31:0]       err_set;
    logic              wr_mode, wr_ctrl, wr_rst, wr_done, wr_dmsk, wr_err, wr_emsk, wr_addr;
    logic              accept, misalign;

    // Decode the write strobe per register.
    always_comb begin
        wr_mode = reg_wr && (reg_addr == OFS_MODE);
        wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
        wr_rst  = reg_wr && (reg_addr == OFS_RST);
        wr_done = reg_wr && (reg_addr == OFS_DONE);
        wr_dmsk = reg_wr && (reg_addr == OFS_DONE_MSK);
        wr_err  = reg_wr && (reg_addr == OFS_ERR);
        wr_emsk = reg_wr && (reg_addr == OFS_ERR_MSK);
        wr_addr = reg_wr && (reg_addr == OFS_ADDR);
    end

    // Decide the fate of a start request.
    always_comb begin
        accept     = wr_ctrl && reg_wdata[0] && !xfer_busy && chan_rel[mode_q.ch];
        misalign   = |addr_q[ALIGN_LSB-1:0];
        start_go   = accept && !misalign && !xfer_empty;
        start_ch   = mode_q.ch;
        start_incr = mode_q.incr;
        start_addr = addr_q;
    end

    // Build the status set vectors from completions and refused starts.
    always_comb begin
        done_set = '0;
        err_set  = '0;
        if (xfer_done)
            done_set[(xfer_done_ch == CH_TO_MEM) ? DONE1_POS : DONE_CH0_BIT] = 1'b1;
        if (accept && !misalign && xfer_empty)
            done_set[(mode_q.ch == CH_TO_MEM) ? DONE1_POS : DONE_CH0_BIT] = 1'b1;
        if (accept && misalign)
            err_set[(mode_q.ch == CH_TO_MEM) ? ERR_CH1_BIT : ERR_CH0_BIT] = 1'b1;
    end

    // Register state update; status clears by written zeros, sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '{ch: CH_TO_CARD, width: 2'b00, incr: 1'b0};
            addr_q   <= '0;
            chan_rel <= 2'b11;
            done_msk <= '1;
            err_msk  <= '1;
            done_st  <= '0;
            err_st   <= '0;
        end else begin
            if (wr_mode)
                mode_q <= '{ch: dma_ch_e'(reg_wdata[MODE_CH_BIT]),
                            width: reg_wdata[MODE_WID_LO+1:MODE_WID_LO],
                            incr: reg_wdata[MODE_INCR_BIT]};
            if (wr_addr) addr_q   <= reg_wdata[ADDR_W-1:0];
            if (wr_rst)  chan_rel <= {reg_wdata[RST_CH1_BIT], reg_wdata[RST_CH0_BIT]};
            if (wr_dmsk) done_msk <= reg_wdata;
            if (wr_emsk) err_msk  <= reg_wdata;
            done_st <= (wr_done ? (done_st & reg_wdata) : done_st) | done_set;
            err_st  <= (wr_err  ? (err_st  & reg_wdata) : err_st)  | err_set;
        end
    end

    // Interrupt: any unmasked status bit.
    always_comb irq = |(done_st & ~done_msk) || |(err_st & ~err_msk);

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_MODE: begin
                reg_rdata[MODE_CH_BIT]                   = mode_q.ch;
                reg_rdata[MODE_WID_LO+1:MODE_WID_LO]     = mode_q.width;
                reg_rdata[MODE_INCR_BIT]                 = mode_q.incr;
            end
            OFS_CTRL:     reg_rdata[0] = xfer_busy;
            OFS_RST: begin
                reg_rdata              = '1;
                reg_rdata[RST_CH0_BIT] = chan_rel[0];
                reg_rdata[RST_CH1_BIT] = chan_rel[1];
            end
            OFS_DONE:     reg_rdata = done_st;
            OFS_DONE_MSK: reg_rdata = done_msk;
            OFS_ERR:      reg_rdata = err_st;
            OFS_ERR_MSK:  reg_rdata = err_msk;
            OFS_ADDR:     reg_rdata[ADDR_W-1:0] = addr_q;
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sd_dma_xfer.sv
// Beat sequencer for one active transfer of the SD host DMA engine.
// Loads channel, addressing mode, address and beat count on go; issues one
// memory request per beat while the card side can take or give a word;
// stops on the last accepted beat or when the channel's soft reset drops.
// Assumes go is only raised while idle.
module sd_dma_xfer
    import sd_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 46,
    parameter int BEAT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  dma_ch_e           go_ch,
    input  logic              go_incr,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [CNT_W-1:0]  go_beats,
    input  logic [1:0]        chan_rel,
    input  logic              mem_rdy,
    input  logic              card_rx_valid,
    input  logic              card_tx_ready,
    output logic              busy,
    output dma_ch_e           cur_ch,
    output logic              cur_incr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fire,
    output logic              done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic              abort, last;

    // Request gating and beat-completion decode.
    always_comb begin
        abort    = busy && !chan_rel[cur_ch];
        mem_req  = busy && !abort &&
                   ((cur_ch == CH_TO_MEM) ? card_rx_valid : card_tx_ready);
        fire     = mem_req && mem_rdy;
        last     = (left_q == CNT_W'(1));
        done     = fire && last;
        mem_addr = addr_q;
    end

    // Transfer state: load, abort, advance per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cur_ch   <= CH_TO_CARD;
            cur_incr <= 1'b0;
            addr_q   <= '0;
            left_q   <= '0;
        end else if (go) begin
            busy     <= 1'b1;
            cur_ch   <= go_ch;
            cur_incr <= go_incr;
            addr_q   <= go_addr;
            left_q   <= go_beats;
        end else if (abort) begin
            busy     <= 1'b0;
        end else if (fire) begin
            left_q   <= left_q - CNT_W'(1);
            if (cur_incr) addr_q <= addr_q + STEP;
            if (last)     busy   <= 1'b0;
        end
    end
endmodule

// File: rtl/sd_dma_engine.sv
// Top of the SD host single-segment DMA engine.
// Derives the beat count from block size and count, joins register file and
// beat sequencer, and steers data between the memory beat bus and the card
// FIFOs according to the active channel. Assumes 64-bit beats.
module sd_dma_engine
    import sd_dma_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int DATA_W        = 64,
    parameter int BSZ_W         = 16,
    parameter int BCNT_W        = 32,
    parameter int ALIGN_LSB     = 7,
    parameter int LEGACY_LAYOUT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [BSZ_W-1:0]  blk_size,
    input  logic [BCNT_W-1:0] blk_count,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    input  logic              card_rx_valid,
    input  logic [DATA_W-1:0] card_rx_data,
    output logic              card_rx_pop,
    output logic              card_tx_valid,
    output logic [DATA_W-1:0] card_tx_data,
    input  logic              card_tx_ready,
    output logic              irq
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BEAT_SH    = $clog2(BEAT_BYTES);
    localparam int TOT_W      = BSZ_W + BCNT_W;
    localparam int CNT_W      = TOT_W + 1 - BEAT_SH;

    logic [TOT_W-1:0]  tot_bytes;
    logic [TOT_W:0]    tot_round;
    logic [CNT_W-1:0]  beats;
    logic              xfer_empty;
    logic              start_go, start_incr;
    dma_ch_e           start_ch;
    logic [ADDR_W-1:0] start_addr;
    logic [1:0]        chan_rel;
    logic              xfer_busy, xfer_incr, beat_fire, xfer_done;
    dma_ch_e           xfer_ch;
    logic [31:0]       reg_done_st, reg_err_st;

    // Byte total rounded up to whole beats.
    always_comb begin
        tot_bytes  = TOT_W'(blk_size) * TOT_W'(blk_count);
        tot_round  = {1'b0, tot_bytes} + (TOT_W+1)'(BEAT_BYTES - 1);
        beats      = tot_round[TOT_W:BEAT_SH];
        xfer_empty = (beats == '0);
    end

    sd_dma_regs #(
        .ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB), .LEGACY_LAYOUT(LEGACY_LAYOUT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_busy(xfer_busy), .xfer_done(xfer_done), .xfer_done_ch(xfer_ch),
        .xfer_empty(xfer_empty),
        .start_go(start_go), .start_ch(start_ch), .start_incr(start_incr),
        .start_addr(start_addr), .chan_rel(chan_rel), .irq(irq),
        .done_st(reg_done_st), .err_st(reg_err_st)
    );

    sd_dma_xfer #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)
    ) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .go(start_go), .go_ch(start_ch), .go_incr(start_incr), .go_addr(start_addr),
        .go_beats(beats), .chan_rel(chan_rel),
        .mem_rdy(mem_rdy), .card_rx_valid(card_rx_valid), .card_tx_ready(card_tx_ready),
        .busy(xfer_busy), .cur_ch(xfer_ch), .cur_incr(xfer_incr),
        .mem_req(mem_req), .mem_addr(mem_addr), .fire(beat_fire), .done(xfer_done)
    );

    // Data steering between the memory beat bus and the card FIFOs.
    always_comb begin
        mem_we        = xfer_busy && (xfer_ch == CH_TO_MEM);
        mem_wdata     = card_rx_data;
        card_rx_pop   = beat_fire && (xfer_ch == CH_TO_MEM);
        card_tx_valid = beat_fire && (xfer_ch == CH_TO_CARD);
        card_tx_data  = mem_rdata;
    end
endmodule

// File: rtl/sd_dma_checker.sv
// Protocol checker for the SD host DMA engine, bound to every instance.
// Watches the beat bus, the sequencer state and the status words.
module sd_dma_checker #(
    parameter int ADDR_W    = 32,
    parameter int ALIGN_LSB = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ch,
    input logic              incr,
    input logic [1:0]        chan_rel,
    input logic              mem_req,
    input logic              mem_rdy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq,
    input logic [31:0]       done_st,
    input logic [31:0]       err_st
);
    // R4: no memory traffic while idle
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    // R4: card-to-memory channel only writes memory
    p_to_mem_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ch) |-> mem_we);
    // R5: memory-to-card channel only reads memory
    p_to_card_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !ch) |-> !mem_we);
    // R6: fixed addressing never moves the address during a transfer
    p_fixed_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !incr) |=> (!busy || $stable(mem_addr)));
    // R6: incrementing addressing steps by one beat per accepted beat
    p_incr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && incr && mem_req && mem_rdy) |=> (!busy || (mem_addr == $past(mem_addr) + 8)));
    // R9: a transfer only begins on an aligned address
    p_aligned_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_addr[ALIGN_LSB-1:0] == '0));
    // R10: dropping the active channel's reset ends the transfer
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !chan_rel[ch]) |=> !busy);
    // R11: an interrupt needs some pending status
    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((done_st != '0) || (err_st != '0)));
endmodule

bind sd_dma_engine sd_dma_checker #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(xfer_busy), .ch(xfer_ch), .incr(xfer_incr),
    .chan_rel(chan_rel), .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_we(mem_we),
    .mem_addr(mem_addr), .irq(irq), .done_st(reg_done_st), .err_st(reg_err_st)
);

// File: tb/sd_dma_engine_bench.sv
`timescale 1ns/1ps
module sd_dma_engine_bench;
    import sd_dma_pkg::*;

    typedef struct packed {
        logic [31:0] a;
        logic        we;
        logic [63:0] d;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, lg_rdata;
    logic [15:0] blk_size = '0;
    logic [31:0] blk_count = '0;
    logic        mem_req, mem_we, lg_req, lg_we;
    logic [31:0] mem_addr, lg_addr;
    logic [63:0] mem_wdata, mem_rdata, lg_wdata;
    logic        mem_rdy = 1'b0;
    logic        card_rx_valid = 1'b1;
    logic [63:0] card_rx_data;
    logic        card_rx_pop, card_tx_valid, lg_pop, lg_txv;
    logic [63:0] card_tx_data, lg_txd;
    logic        card_tx_ready = 1'b0;
    logic        irq, lg_irq;
    logic        rdy_en = 1'b1;
    logic [31:0] rx_idx = '0;
    logic [31:0] exp_rx = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    beat_t       q[$];

    always #2.5 clk = ~clk;

    assign card_rx_data = {rx_idx, ~rx_idx};
    assign mem_rdata    = {~mem_addr, mem_addr};

    sd_dma_engine u_sd_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .blk_size(blk_size), .blk_count(blk_count),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data), .card_rx_pop(card_rx_pop),
        .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data),
        .card_tx_ready(card_tx_ready), .irq(irq)
    );

    sd_dma_engine #(.LEGACY_LAYOUT(1)) u_sd_dma_engine_legacy (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(lg_rdata),
        .blk_size(blk_size), .blk_count(blk_count),
        .mem_req(lg_req), .mem_we(lg_we), .mem_addr(lg_addr),
        .mem_wdata(lg_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data), .card_rx_pop(lg_pop),
        .card_tx_valid(lg_txv), .card_tx_data(lg_txd),
        .card_tx_ready(card_tx_ready), .irq(lg_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    // Driver: queue the beats a transfer must produce.
    task automatic push_beats(input logic ch, input logic incr, input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            beat_t b;
            b.a  = incr ? base + 32'(8 * i) : base;
            b.we = ch;
            if (ch) begin
                b.d = {exp_rx, ~exp_rx};
                exp_rx = exp_rx + 1;
            end else begin
                b.d = {~b.a, b.a};
            end
            q.push_back(b);
        end
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int n = 0; n < 3000; n++) begin
            bus_rd(OFS_CTRL, d);
            if (d[0] == 1'b0) break;
        end
        chk("R3 transfer ended (busy bit)", {63'b0, d[0]}, 64'd0);
    endtask

    // Ready patterns for memory and card transmit side.
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            mem_rdy       = rdy_en && (cyc % 3 != 0);
            card_tx_ready = (cyc % 4 != 1);
        end
    end

    // Monitor: pop and compare every accepted beat.
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_rdy) begin
            if (q.size() == 0) begin
                chk("R4 unexpected memory beat (addr)", {32'b0, mem_addr}, 64'hFFFF_FFFF_FFFF_FFFF);
            end else begin
                beat_t e;
                e = q.pop_front();
                chk("R6 beat address", {32'b0, mem_addr}, {32'b0, e.a});
                chk(e.we ? "R4 beat direction" : "R5 beat direction", {63'b0, mem_we}, {63'b0, e.we});
                if (e.we) begin
                    chk("R4 memory write data", mem_wdata, e.d);
                    chk("R4 card pop", {63'b0, card_rx_pop}, 64'd1);
                end else begin
                    chk("R5 card transmit data", card_tx_data, e.d);
                    chk("R5 card transmit valid", {63'b0, card_tx_valid}, 64'd1);
                end
            end
            if (card_rx_pop) rx_idx = rx_idx + 1;
        end
    end

    // Watchdog.
    initial begin
        #750000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_rd(OFS_DONE_MSK, d); chk("R1 completion mask", {32'b0, d}, 64'hFFFF_FFFF);
        bus_rd(OFS_ERR_MSK, d);  chk("R1 error mask", {32'b0, d}, 64'hFFFF_FFFF);
        bus_rd(OFS_DONE, d);     chk("R1 completion status", {32'b0, d}, 64'd0);
        bus_rd(OFS_ERR, d);      chk("R1 error status", {32'b0, d}, 64'd0);
        bus_rd(OFS_RST, d);      chk("R1 reset register", {32'b0, d}, 64'hFFFF_FFFF);
        bus_rd(OFS_CTRL, d);     chk("R1 control idle", {32'b0, d}, 64'd0);
        chk("R1 irq low", {63'b0, irq}, 64'd0);

        // R2 mode and address readback
        bus_wr(OFS_MODE, 32'hFFFF_FFFF);
        bus_rd(OFS_MODE, d); chk("R2 mode keeps only its fields", {32'b0, d}, 64'h0001_0031);
        bus_wr(OFS_MODE, 32'h0000_0020);
        bus_rd(OFS_MODE, d); chk("R2 mode width code", {32'b0, d}, 64'h0000_0020);

        // T1: channel 1, incrementing, 16 x 8 blocks = 16 beats
        blk_size = 16; blk_count = 8;
        bus_wr(OFS_MODE, 32'h0001_0001);
        bus_wr(OFS_ADDR, 32'h0000_1000);
        bus_rd(OFS_ADDR, d); chk("R2 address readback", {32'b0, d}, 64'h1000);
        push_beats(1'b1, 1'b1, 32'h1000, 16);
        bus_wr(OFS_CTRL, 32'h1);
        bus_rd(OFS_CTRL, d); chk("R3 busy while active", {63'b0, d[0]}, 64'd1);
        wait_idle();
        chk("R4 all beats delivered", 64'(q.size()), 64'd0);
        bus_rd(OFS_DONE, d); chk("R7 channel 1 completion bit 20", {32'b0, d}, 64'h0010_0000);
        chk("R7 legacy layout uses bit 17", {32'b0, lg_rdata}, 64'h0002_0000);
        chk("R11 masked completion keeps irq low", {63'b0, irq}, 64'd0);

        // R8 / R11 write-zero clear and masking
        bus_wr(OFS_DONE, 32'hFFFF_FFFF);
        bus_rd(OFS_DONE, d); chk("R8 writing ones keeps status", {32'b0, d}, 64'h0010_0000);
        bus_wr(OFS_DONE_MSK, ~32'h0010_0000);
        @(negedge clk); chk("R11 unmasked completion raises irq", {63'b0, irq}, 64'd1);
        bus_wr(OFS_DONE, 32'h0);
        bus_rd(OFS_DONE, d); chk("R8 writing zero clears status", {32'b0, d}, 64'd0);
        chk("R11 irq drops after clear", {63'b0, irq}, 64'd0);
        bus_wr(OFS_DONE_MSK, 32'hFFFF_FFFF);

        // T2: channel 0, fixed address, 24 x 2 = 6 beats
        blk_size = 24; blk_count = 2;
        bus_wr(OFS_MODE, 32'h0000_0000);
        bus_wr(OFS_ADDR, 32'h0000_3000);
        push_beats(1'b0, 1'b0, 32'h3000, 6);
        bus_wr(OFS_CTRL, 32'h1);
        wait_idle();
        chk("R5 all card beats delivered", 64'(q.size()), 64'd0);
        bus_rd(OFS_DONE, d); chk("R7 channel 0 completion bit 16", {32'b0, d}, 64'h0001_0000);
        bus_wr(OFS_DONE, 32'h0);

        // T3: channel 1, 12 x 5 = 60 bytes -> 8 beats; second start while busy
        blk_size = 12; blk_count = 5;
        bus_wr(OFS_MODE, 32'h0001_0001);
        bus_wr(OFS_ADDR, 32'h0000_4000);
        push_beats(1'b1, 1'b1, 32'h4000, 8);
        bus_wr(OFS_CTRL, 32'h1);
        bus_wr(OFS_ADDR, 32'h0000_5000);
        bus_wr(OFS_CTRL, 32'h1);
        wait_idle();
        repeat (30) @(posedge clk);
        chk("R3 start while busy ignored (no extra beats)", 64'(q.size()), 64'd0);
        bus_rd(OFS_CTRL, d); chk("R3 idle after ignored start", {32'b0, d}, 64'd0);
        bus_rd(OFS_DONE, d); chk("R7 rounded transfer completes", {32'b0, d}, 64'h0010_0000);
        bus_wr(OFS_DONE, 32'h0);

        // Zero byte total
        blk_count = 0;
        bus_wr(OFS_MODE, 32'h0000_0001);
        bus_wr(OFS_ADDR, 32'h0000_6000);
        bus_wr(OFS_CTRL, 32'h1);
        bus_rd(OFS_CTRL, d); chk("R7 zero length never busy", {32'b0, d}, 64'd0);
        bus_rd(OFS_DONE, d); chk("R7 zero length completes", {32'b0, d}, 64'h0001_0000);
        bus_wr(OFS_DONE, 32'h0);
        blk_size = 16; blk_count = 4;

        // Misaligned start on channel 1
        bus_wr(OFS_MODE, 32'h0001_0001);
        bus_wr(OFS_ADDR, 32'h0000_2040);
        bus_wr(OFS_CTRL, 32'h1);
        bus_rd(OFS_CTRL, d); chk("R9 misaligned never busy", {32'b0, d}, 64'd0);
        bus_rd(OFS_ERR, d);  chk("R9 channel 1 error bit 17", {32'b0, d}, 64'h0002_0000);
        bus_rd(OFS_DONE, d); chk("R9 no completion on error", {32'b0, d}, 64'd0);
        chk("R11 masked error keeps irq low", {63'b0, irq}, 64'd0);
        bus_wr(OFS_ERR_MSK, ~32'h0002_0000);
        @(negedge clk); chk("R11 unmasked error raises irq", {63'b0, irq}, 64'd1);
        bus_wr(OFS_ERR, 32'h0);
        @(negedge clk); chk("R8 error cleared, irq low", {63'b0, irq}, 64'd0);
        bus_wr(OFS_MODE, 32'h0000_0001);
        bus_wr(OFS_CTRL, 32'h1);
        bus_rd(OFS_ERR, d); chk("R9 channel 0 error bit 16", {32'b0, d}, 64'h0001_0000);
        bus_wr(OFS_ERR, 32'h0);
        bus_wr(OFS_ERR_MSK, 32'hFFFF_FFFF);
        repeat (10) @(posedge clk);
        chk("R9 misaligned start moved no data", 64'(q.size()), 64'd0);

        // Soft reset abort on channel 0 with memory stalled
        rdy_en = 1'b0;
        repeat (3) @(posedge clk);
        bus_wr(OFS_ADDR, 32'h0000_7000);
        bus_wr(OFS_CTRL, 32'h1);
        bus_rd(OFS_CTRL, d); chk("R3 busy before abort", {32'b0, d}, 64'd1);
        bus_wr(OFS_RST, 32'hFFFF_FEFF);
        bus_rd(OFS_CTRL, d); chk("R10 abort clears busy", {32'b0, d}, 64'd0);
        bus_rd(OFS_DONE, d); chk("R10 abort sets no completion", {32'b0, d}, 64'd0);
        bus_rd(OFS_RST, d);  chk("R10 reserved bits read one", {32'b0, d}, 64'hFFFF_FEFF);
        bus_wr(OFS_CTRL, 32'h1);
        bus_rd(OFS_CTRL, d); chk("R10 start ignored while held", {32'b0, d}, 64'd0);
        bus_wr(OFS_RST, 32'hFFFF_FFFF);
        rdy_en = 1'b1;
        repeat (30) @(posedge clk);
        chk("R10 no beats after abort", 64'(q.size()), 64'd0);
        bus_rd(OFS_DONE, d); chk("R10 still no completion", {32'b0, d}, 64'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule